// File: doc/BRIEF.md
# Bytewide RAM with Clock Window

This block models a 2048 x 8 static RAM on a synchronous clock, with a bus that looks asynchronous: a chip enable, an output enable, a write enable, an 11-bit address, and separate 8-bit write and read data paths. A single-byte access uses the same bus cycle at every address. The eight highest addresses do not reach the storage array. They form a window onto a timekeeping unit: one control byte plus seven counter registers. The calendar counters live outside this block. The block receives them on a 56-bit input and returns new values on a 56-bit output with a load strobe.

Reads from the window return a snapshot. While the read flag is clear, the snapshot follows the live counters. While the read flag is set, the snapshot stays frozen. Writes to the window go into a staging buffer. The counter logic is told to load that buffer when software clears the write flag. A power-fail input blocks every write, to the array and to the window alike. A read puts data on the bus, with the drive enable high, only during a true read cycle.

Top module: `tk_ram`

## Requirements
- R1: For any address below 0x7F8, a write cycle (chip_en=1, wr_en=1) stores wdata. A later read cycle returns that byte on rdata in the cycle after the read is presented.
- R2: drive_en is 1 in the cycle after chip_en=1, out_en=1, wr_en=0 are presented, and 0 otherwise. While drive_en is 0, rdata is 0x00. A cycle with both out_en and wr_en high is a write and does not drive the bus.
- R3: Address 0x7F8 is the control byte. Bit 7 is the write flag and bit 6 is the read flag. A read of this address returns {write flag, read flag, 6'b0}.
- R4: Addresses 0x7F9 to 0x7FF select seconds, minutes, hours, weekday, date, month and year, in that order. These map to bytes 0 to 6 of live_time and load_time (byte k is bits 8k+7:8k).
- R5: While the read flag is clear, the snapshot captures live_time at every clock edge. A window read therefore returns live_time as sampled at the edge before the read edge.
- R6: Writing the control byte with bit 6 set freezes the snapshot at the live_time value sampled on that same edge. Later counter changes do not affect reads until bit 6 is cleared.
- R7: Writing the control byte so that bit 7 goes from 0 to 1 copies live_time into the staging buffer. Writes to 0x7F9 to 0x7FF replace single staged bytes. load_time always presents the staging buffer.
- R8: A control write that clears bit 7 while the write flag is set produces a single-cycle load_stb in the next cycle. load_stb stays 0 at all other times.
- R9: While pwr_fail is 1, all writes are ignored: the array, the control flags and the staging buffer keep their contents, and load_stb stays 0.
- R10: After reset, drive_en, rdata, load_stb, load_time and both control flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail | input | 1 | Power-fail indication; blocks writes |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| wr_en | input | 1 | Write enable, active high |
| addr | input | 11 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, 0 when not driven |
| drive_en | output | 1 | Tri-state enable for rdata |
| live_time | input | 56 | Live counters from the calendar logic |
| load_time | output | 56 | Staged counter values |
| load_stb | output | 1 | One-cycle request to load load_time |

## Verification
Two functions can land on the same edge. The external counters can change on the edge that sets the read flag, and the write flag can be released while the counters are moving. The bench advances live_time on every cycle, including the cycle in which the freeze or release write is presented. It then checks that the frozen snapshot equals the value sampled on that edge, and that the staged bytes stay as written. A behavioural model in the bench predicts rdata, drive_en, load_stb and load_time on every clock, and these are compared against the design.

// File: rtl/tk_ram.sv
module tk_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_fail,
  input  logic            chip_en,
  input  logic            out_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            drive_en,
  input  logic [7*DW-1:0] live_time,
  output logic [7*DW-1:0] load_time,
  output logic            load_stb
);
  localparam int NREG = 7;
  localparam int TW   = NREG * DW;
  localparam int BASE = (1 << AW) - 8;

  logic [DW-1:0] mem [0:BASE-1];
  logic          wflag, rflag;
  logic [TW-1:0] snap, stage;
  logic [DW-1:0] win_byte;

  wire       wr_cyc  = chip_en & wr_en & ~pwr_fail;
  wire       rd_cyc  = chip_en & out_en & ~wr_en;
  wire       in_win  = addr >= AW'(BASE);
  wire [2:0] sel     = addr[2:0];
  wire       ctrl_wr = wr_cyc & in_win & (sel == 3'd0);

  assign load_time = stage;

  always_comb begin
    win_byte = {wflag, rflag, {(DW-2){1'b0}}};
    for (int i = 1; i <= NREG; i++)
      if (sel == 3'(i)) win_byte = snap[(i-1)*DW +: DW];
  end

  always_ff @(posedge clk)
    if (wr_cyc && !in_win) mem[addr] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_en <= 1'b0;
      rdata    <= '0;
    end else begin
      drive_en <= rd_cyc;
      rdata    <= !rd_cyc ? '0 : (in_win ? win_byte : mem[addr]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wflag    <= 1'b0;
      rflag    <= 1'b0;
      snap     <= '0;
      stage    <= '0;
      load_stb <= 1'b0;
    end else begin
      if (!rflag) snap <= live_time;
      load_stb <= ctrl_wr & wflag & ~wdata[DW-1];
      if (ctrl_wr) begin
        wflag <= wdata[DW-1];
        rflag <= wdata[DW-2];
        if (wdata[DW-1] && !wflag) stage <= live_time;
      end else if (wr_cyc && in_win) begin
        for (int i = 1; i <= NREG; i++)
          if (sel == 3'(i)) stage[(i-1)*DW +: DW] <= wdata;
      end
    end
  end

  // R9
  pf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> ($stable(load_time) && !load_stb));
  // R2
  drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && out_en && !wr_en) |=> drive_en);
  // R2
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_en && out_en && !wr_en) |=> (!drive_en && rdata == '0));
  // R5
  snap_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rflag |=> (snap == $past(live_time)));
  // R6
  snap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rflag |=> $stable(snap));
  // R8
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
endmodule

// File: tb/test_tk_ram.sv
`timescale 1ns/1ps
module test_tk_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_fail = 1'b0, chip_en = 1'b0, out_en = 1'b0, wr_en = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        drive_en, load_stb;
  logic [55:0] live_time = '0, load_time;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R10";
  bit    live_run = 1'b0;
  bit    active = 1'b0;

  always #2.5 clk = ~clk;

  tk_ram i_tk_ram (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .chip_en(chip_en),
    .out_en(out_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drive_en(drive_en), .live_time(live_time),
    .load_time(load_time), .load_stb(load_stb)
  );

  logic [7:0]  mem_m [int];
  logic        m_w, m_r, m_drive, m_load;
  logic [7:0]  m_rdata;
  logic [55:0] m_snap, m_stage;

  always @(posedge clk) begin
    bit wr, rd;
    int k;
    if (!rst_n) begin
      m_w = 0; m_r = 0; m_snap = '0; m_stage = '0;
      m_drive = 0; m_rdata = '0; m_load = 0;
    end else begin
      wr = chip_en && wr_en && !pwr_fail;
      rd = chip_en && out_en && !wr_en;
      k  = int'(addr) - 'h7F9;
      m_drive = rd;
      m_rdata = '0;
      if (rd) begin
        if (addr < 11'h7F8) m_rdata = mem_m[int'(addr)];
        else if (addr == 11'h7F8) m_rdata = {m_w, m_r, 6'b0};
        else m_rdata = m_snap[k*8 +: 8];
      end
      m_load = wr && addr == 11'h7F8 && m_w && !wdata[7];
      if (!m_r) m_snap = live_time;
      if (wr) begin
        if (addr < 11'h7F8) mem_m[int'(addr)] = wdata;
        else if (addr == 11'h7F8) begin
          if (wdata[7] && !m_w) m_stage = live_time;
          m_w = wdata[7];
          m_r = wdata[6];
        end else m_stage[k*8 +: 8] = wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (active) begin
      n_cmp++;
      if (rdata !== m_rdata || drive_en !== m_drive || load_stb !== m_load ||
          load_time !== m_stage) begin
        n_bad++;
        $display("FAIL %s model: rdata=%h/%h drive=%b/%b stb=%b/%b load=%h/%h (actual/expected)",
                 cur_req, rdata, m_rdata, drive_en, m_drive, load_stb, m_load,
                 load_time, m_stage);
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit c, bit o, bit w, logic [10:0] a, logic [7:0] d);
    chip_en = c; out_en = o; wr_en = w; addr = a; wdata = d;
    if (live_run) live_time = live_time + 56'h01_03_05_07_09_0B_0D;
    @(negedge clk);
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d); cyc(1, 0, 1, a, d); endtask
  task automatic rd(logic [10:0] a);                 cyc(1, 1, 0, a, 8'h00); endtask
  task automatic idle();                             cyc(0, 0, 0, 11'h0, 8'h00); endtask

  task automatic rd_chk(string req, logic [10:0] a, logic [7:0] exp);
    rd(a);
    check(req, {55'b0, drive_en, rdata}, {55'b0, 1'b1, exp});
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R10", {load_stb, drive_en, rdata, load_time}, '0);
    rst_n = 1'b1;
    active = 1'b1;
    rd_chk("R10", 11'h7F8, 8'h00);

    cur_req = "R1";
    wr(11'h000, 8'hA5); wr(11'h123, 8'h3C); wr(11'h7F7, 8'h5A);
    rd_chk("R1", 11'h000, 8'hA5);
    rd_chk("R1", 11'h7F7, 8'h5A);
    rd_chk("R1", 11'h123, 8'h3C);

    cur_req = "R2";
    cyc(1, 1, 1, 11'h123, 8'h77);
    check("R2", {drive_en, rdata}, 9'h000);
    cyc(0, 1, 0, 11'h123, 8'h00);
    check("R2", {drive_en, rdata}, 9'h000);
    rd_chk("R2", 11'h123, 8'h77);

    cur_req = "R5";
    live_run = 1'b1;
    for (int i = 0; i < 7; i++) rd(11'h7F9 + 11'(i));
    idle();

    cur_req = "R6";
    live_run = 1'b0;
    live_time = 56'h07_06_05_04_03_02_01;
    cyc(1, 0, 1, 11'h7F8, 8'h40);
    live_time = 56'h77_66_55_44_33_22_11;
    idle();
    rd_chk("R4", 11'h7F9, 8'h01);
    rd_chk("R4", 11'h7FB, 8'h03);
    rd_chk("R4", 11'h7FF, 8'h07);
    rd_chk("R3", 11'h7F8, 8'h40);
    live_run = 1'b1;
    for (int i = 0; i < 7; i++) rd(11'h7F9 + 11'(i));
    wr(11'h7F8, 8'h00);
    for (int i = 0; i < 4; i++) rd(11'h7F9 + 11'(i));

    cur_req = "R7";
    live_run = 1'b0;
    live_time = 56'h20_12_31_06_23_59_58;
    wr(11'h7F8, 8'h80);
    live_run = 1'b1;
    wr(11'h7FB, 8'h11);
    check("R7", load_time, 56'h20_12_31_06_11_59_58);
    rd_chk("R3", 11'h7F8, 8'h80);
    wr(11'h7FF, 8'h99);
    cur_req = "R8";
    wr(11'h7F8, 8'h00);
    check("R8", {load_stb, load_time}, {1'b1, 56'h99_12_31_06_11_59_58});
    idle();
    check("R8", {63'b0, load_stb}, 64'h0);
    wr(11'h7F8, 8'h00);
    check("R8", {63'b0, load_stb}, 64'h0);

    cur_req = "R9";
    pwr_fail = 1'b1;
    wr(11'h000, 8'hFF); wr(11'h7F8, 8'hC0); wr(11'h7FA, 8'h42); wr(11'h7F8, 8'h00);
    check("R9", {load_stb, load_time}, {1'b0, 56'h99_12_31_06_11_59_58});
    pwr_fail = 1'b0;
    rd_chk("R9", 11'h000, 8'hA5);
    rd_chk("R9", 11'h7F8, 8'h00);

    cur_req = "R4";
    for (int i = 0; i < 8; i++) wr(11'h7F0 + 11'(i), 8'(i * 17 + 3));
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      pwr_fail = (r[9:8] == 2'b00);
      cyc(r[0] | r[1], r[2], r[3] & r[4], 11'h7F0 | 11'(r[7:5] + (r[10] ? 8 : 0)), r[23:16]);
    end
    pwr_fail = 1'b0;
    idle(); idle();

    active = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule